// File: doc/BRIEF.md
# Saturating Cache Event Counter Unit

This unit counts cache events for performance analysis. Software reaches it through a plain register read/write port. It holds two identical counters. Each counter has its own configuration register that picks one line of a 15-bit event-pulse vector. A counter adds one on every cycle that its chosen line is high, provided the shared global enable is set.

The counters do not wrap. When a counter reaches all-ones it stays there. It can then raise a sticky pending flag, which feeds a single interrupt output through a mask bit. Software rewrites a counter value only after it has set that counter's event select to zero. A write made while the counter is still selecting an event is dropped.

Read data is registered. The word for a read appears on the clock edge after the read strobe.

Top module: `satEvtMon`

## Requirements
- R1: After reset every register, both counters, the read data and the interrupt output are zero.
- R2: With the global enable set and an event select of k (1 to 15), a counter adds one on each cycle that event-pulse bit k-1 is high and ignores all other bits. A select of 0 never counts.
- R3: A counter that reaches all-ones (255 with an 8-bit width) holds that value while further events arrive.
- R4: A write to a counter value register loads the counter only while that counter's select field is 0. Otherwise the write is dropped and the counter keeps its value.
- R5: Bit 0 of the control register at offset 0x00 is the global enable. While it is clear, no counter changes on events.
- R6: The configuration register of counter i is at offset 0x24 - 4*i and its value register is at 0x2C - 4*i. In the configuration word, bits [3:0] hold the event select and bit 8 holds the saturation interrupt enable.
- R7: Bit 0 of the raw status at offset 0x08 is set on the cycle an increment brings a counter with its interrupt enable set to all-ones. It stays set when the counter is later rewritten. A register write of all-ones, or saturation with the interrupt enable clear, does not set it.
- R8: Writing 1 to bit 0 at offset 0x10 clears the pending bit, and writing 0 there does nothing. When a set and a clear happen in the same cycle, the set wins.
- R9: Bit 0 at offset 0x04 is the interrupt mask. The output interrupt and bit 0 of the masked status at offset 0x0C both equal the pending bit AND the mask.
- R10: Read data is loaded on the edge that samples the read strobe and holds between reads. An unmapped offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| evtPulse | input | NUM_EVT | Single-cycle event pulses from the cache |
| irqOut | output | 1 | Masked counter interrupt |

## Verification
The bench builds the unit with an 8-bit counter width and keeps all 15 event lines. With 8-bit counters, saturation and the interrupt edge at all-ones are reached in a few cycles instead of four billion. Because the event vector is kept at full width, the bench can sweep every select code on both counters. Each select code is driven both with its own line low and the other lines high, and with its own line high. The expected counts are computed as simple sums.

// File: rtl/satEvtPkg.sv
`timescale 1ns/1ps
package satEvtPkg;

  localparam int NUM_CTR = 2;
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

  // Byte offsets; per-counter registers step downward for higher indices.
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_MASK   = 'h04;
  localparam int OFS_RAW    = 'h08;
  localparam int OFS_MASKED = 'h0C;
  localparam int OFS_CLR    = 'h10;
  localparam int OFS_CFG0   = 'h24;
  localparam int OFS_VAL0   = 'h2C;
  localparam int OFS_STEP   = 4;

  localparam int CFG_IRQEN_BIT = 8;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CTRL,
    RD_MASK,
    RD_RAW,
    RD_MASKED,
    RD_CFG,
    RD_VAL
  } rdSel_e;

  typedef struct packed {
    logic               wrCtrl;
    logic               wrMask;
    logic               wrClr;
    logic [NUM_CTR-1:0] wrCfg;
    logic [NUM_CTR-1:0] wrVal;
    logic               rdEn;
    rdSel_e             rdSel;
    logic [IDX_W-1:0]   rdIdx;
  } strobe_t;

endpackage

// File: rtl/satEvtCtrl.sv
`timescale 1ns/1ps
module satEvtCtrl
  import satEvtPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe
);

  logic [NUM_CTR-1:0] cfgHit;
  logic [NUM_CTR-1:0] valHit;

  for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_dec
    assign cfgHit[gi] = (regAddr == ADDR_W'(OFS_CFG0 - OFS_STEP * gi));
    assign valHit[gi] = (regAddr == ADDR_W'(OFS_VAL0 - OFS_STEP * gi));
  end

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_ZERO;
    strobe.rdEn   = regRdEn;
    strobe.wrCtrl = regWrEn && (regAddr == ADDR_W'(OFS_CTRL));
    strobe.wrMask = regWrEn && (regAddr == ADDR_W'(OFS_MASK));
    strobe.wrClr  = regWrEn && (regAddr == ADDR_W'(OFS_CLR));
    strobe.wrCfg  = regWrEn ? cfgHit : '0;
    strobe.wrVal  = regWrEn ? valHit : '0;

    if (regAddr == ADDR_W'(OFS_CTRL))        strobe.rdSel = RD_CTRL;
    else if (regAddr == ADDR_W'(OFS_MASK))   strobe.rdSel = RD_MASK;
    else if (regAddr == ADDR_W'(OFS_RAW))    strobe.rdSel = RD_RAW;
    else if (regAddr == ADDR_W'(OFS_MASKED)) strobe.rdSel = RD_MASKED;

    for (int i = 0; i < NUM_CTR; i++) begin
      if (cfgHit[i]) begin
        strobe.rdSel = RD_CFG;
        strobe.rdIdx = IDX_W'(i);
      end
      if (valHit[i]) begin
        strobe.rdSel = RD_VAL;
        strobe.rdIdx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/satEvtDatapath.sv
`timescale 1ns/1ps
module satEvtDatapath
  import satEvtPkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 15,
  parameter int SEL_W   = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strobe,
  input  logic [31:0]                     regWrData,
  input  logic [NUM_EVT-1:0]              evtPulse,
  output logic [31:0]                     regRdData,
  output logic                            irqOut,
  output logic [NUM_CTR-1:0][CNT_W-1:0]   ctrVal,
  output logic [NUM_CTR-1:0][SEL_W-1:0]   ctrSel,
  output logic                            globalEn,
  output logic                            irqMask,
  output logic                            irqRaw
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - CNT_W'(1);

  logic [NUM_CTR-1:0] ctrIrqEn;
  logic [NUM_CTR-1:0] reachMax;

  for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
    logic selHit;
    logic doInc;

    always_comb begin
      selHit = 1'b0;
      for (int e = 0; e < NUM_EVT; e++) begin
        if (ctrSel[gi] == SEL_W'(e + 1)) selHit = evtPulse[e];
      end
    end

    assign doInc        = globalEn && selHit && (ctrVal[gi] != CNT_MAX);
    assign reachMax[gi] = doInc && ctrIrqEn[gi] && (ctrVal[gi] == CNT_NEAR);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrSel[gi]   <= '0;
        ctrIrqEn[gi] <= 1'b0;
      end else if (strobe.wrCfg[gi]) begin
        ctrSel[gi]   <= regWrData[SEL_W-1:0];
        ctrIrqEn[gi] <= regWrData[CFG_IRQEN_BIT];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrVal[gi] <= '0;
      end else if (strobe.wrVal[gi] && (ctrSel[gi] == '0)) begin
        ctrVal[gi] <= regWrData[CNT_W-1:0];
      end else if (doInc) begin
        ctrVal[gi] <= ctrVal[gi] + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      irqMask  <= 1'b0;
      irqRaw   <= 1'b0;
    end else begin
      if (strobe.wrCtrl) globalEn <= regWrData[0];
      if (strobe.wrMask) irqMask  <= regWrData[0];
      if (|reachMax)                            irqRaw <= 1'b1;
      else if (strobe.wrClr && regWrData[0])    irqRaw <= 1'b0;
    end
  end

  assign irqOut = irqRaw && irqMask;

  logic [31:0] rdWord;

  always_comb begin
    rdWord = '0;
    case (strobe.rdSel)
      RD_CTRL:   rdWord[0] = globalEn;
      RD_MASK:   rdWord[0] = irqMask;
      RD_RAW:    rdWord[0] = irqRaw;
      RD_MASKED: rdWord[0] = irqRaw && irqMask;
      RD_CFG: begin
        rdWord[SEL_W-1:0]    = ctrSel[strobe.rdIdx];
        rdWord[CFG_IRQEN_BIT] = ctrIrqEn[strobe.rdIdx];
      end
      RD_VAL:    rdWord[CNT_W-1:0] = ctrVal[strobe.rdIdx];
      default:   rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            regRdData <= '0;
    else if (strobe.rdEn) regRdData <= rdWord;
  end

endmodule

// File: rtl/satEvtMon.sv
`timescale 1ns/1ps
module satEvtMon
  import satEvtPkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 15,
  parameter int ADDR_W  = 8,
  parameter int SEL_W   = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic               irqOut
);

  strobe_t                          strobe;
  logic [NUM_CTR-1:0][CNT_W-1:0]    ctrVal;
  logic [NUM_CTR-1:0][SEL_W-1:0]    ctrSel;
  logic                             globalEn;
  logic                             irqMask;
  logic                             irqRaw;

  satEvtCtrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  satEvtDatapath #(
    .CNT_W   (CNT_W),
    .NUM_EVT (NUM_EVT),
    .SEL_W   (SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .evtPulse  (evtPulse),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .ctrVal    (ctrVal),
    .ctrSel    (ctrSel),
    .globalEn  (globalEn),
    .irqMask   (irqMask),
    .irqRaw    (irqRaw)
  );

endmodule

// File: rtl/satEvtMonChk.sv
`timescale 1ns/1ps
module satEvtMonChk #(
  parameter int NUM_CTR = 2,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_CTR-1:0][CNT_W-1:0] ctrVal,
  input logic [NUM_CTR-1:0][SEL_W-1:0] ctrSel,
  input logic [NUM_CTR-1:0]            wrVal,
  input logic                          wrClr,
  input logic                          clrBit,
  input logic                          globalEn,
  input logic                          irqMask,
  input logic                          irqRaw,
  input logic                          irqOut
);

  for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_chk
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      ((&ctrVal[gi]) && !wrVal[gi]) |=> (&ctrVal[gi])); // R3

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
      (!globalEn && !wrVal[gi]) |=> $stable(ctrVal[gi])); // R5

    AST_SEL_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      ((ctrSel[gi] == '0) && !wrVal[gi]) |=> $stable(ctrVal[gi])); // R2

    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (ctrSel[gi] != '0) |=>
        ((ctrVal[gi] == $past(ctrVal[gi])) ||
         (ctrVal[gi] == $past(ctrVal[gi]) + 1'b1))); // R4
  end

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqRaw && !(wrClr && clrBit)) |=> irqRaw); // R7

  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && clrBit && (ctrSel == '0)) |=> !irqRaw); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqMask); // R9

endmodule

bind satEvtMon satEvtMonChk #(
  .NUM_CTR (satEvtPkg::NUM_CTR),
  .CNT_W   (CNT_W),
  .SEL_W   (SEL_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctrVal   (ctrVal),
  .ctrSel   (ctrSel),
  .wrVal    (strobe.wrVal),
  .wrClr    (strobe.wrClr),
  .clrBit   (regWrData[0]),
  .globalEn (globalEn),
  .irqMask  (irqMask),
  .irqRaw   (irqRaw),
  .irqOut   (irqOut)
);

// File: tb/test_satEvtMon.sv
`timescale 1ns/1ps
module test_satEvtMon;

  localparam int CNT_W = 8;
  localparam int NEV   = 15;
  localparam logic [7:0] A_CTRL = 8'h00, A_MASK = 8'h04, A_RAW = 8'h08,
                         A_MSKD = 8'h0C, A_CLR = 8'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NEV-1:0] evtPulse = '0;
  logic        irqOut;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  satEvtMon #(.CNT_W(CNT_W), .NUM_EVT(NEV), .ADDR_W(8)) i_satEvtMon (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evtPulse(evtPulse), .irqOut(irqOut)
  );

  function automatic logic [7:0] cfgAddr(input int c); return 8'(8'h24 - 4 * c); endfunction
  function automatic logic [7:0] valAddr(input int c); return 8'(8'h2C - 4 * c); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic pulse(input logic [NEV-1:0] v, input int n);
    evtPulse = v;
    repeat (n) begin @(posedge clk); #1; end
    evtPulse = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NEV-1:0] bitV;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    check("R1 irqOut", {31'b0, irqOut}, 32'd0);
    check("R1 rdData", regRdData, 32'd0);
    foreach (d[i]) begin end
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_MASK, d); check("R1 mask", d, 0);
    rd(A_RAW,  d); check("R1 raw", d, 0);
    rd(A_MSKD, d); check("R1 masked", d, 0);
    for (int c = 0; c < 2; c++) begin
      rd(cfgAddr(c), d); check("R1 cfg", d, 0);
      rd(valAddr(c), d); check("R1 val", d, 0);
    end

    // R10 read latency, hold, unmapped
    wr(cfgAddr(0), 32'h5);
    rd(cfgAddr(0), d); check("R10 cfg readback", d, 32'h5);
    @(posedge clk); #1;
    check("R10 hold", regRdData, 32'h5);
    rd(8'h40, d); check("R10 unmapped", d, 0);
    rd(8'h03, d); check("R10 unaligned", d, 0);

    // R5 global enable clear blocks counting
    pulse('1, 4);
    rd(valAddr(0), d); check("R5 gate off", d, 0);
    wr(A_CTRL, 1);
    rd(A_CTRL, d); check("R5 ctrl bit", d, 1);

    // R2 / R6 sweep over every select code on both counters
    for (int c = 0; c < 2; c++) begin
      for (int s = 1; s <= NEV; s++) begin
        bitV = NEV'(1) << (s - 1);
        wr(cfgAddr(c), 0);
        wr(valAddr(c), 0);
        wr(cfgAddr(c), 32'(s));
        pulse(~bitV, 3);
        pulse(bitV | NEV'(s * 7), s + 2);
        rd(valAddr(c), d);
        check(c == 0 ? "R2 sweep ctr0" : "R6 sweep ctr1", d, 32'(s + 2));
      end
    end
    wr(cfgAddr(1), 0);

    // R2 select zero never counts
    wr(cfgAddr(0), 0);
    wr(valAddr(0), 9);
    pulse('1, 5);
    rd(valAddr(0), d); check("R2 sel zero", d, 9);

    // R5 again with a live select
    wr(cfgAddr(0), 1);
    wr(A_CTRL, 0);
    pulse('1, 6);
    rd(valAddr(0), d); check("R5 gate live sel", d, 9);
    wr(A_CTRL, 1);

    // R3 saturation, R7 raw set, R9 mask
    wr(cfgAddr(0), 0);
    wr(valAddr(0), 250);
    wr(cfgAddr(0), 32'h103);
    pulse(NEV'(4), 10);
    rd(valAddr(0), d); check("R3 saturate", d, 255);
    rd(A_RAW, d); check("R7 raw set", d, 1);
    check("R9 masked off", {31'b0, irqOut}, 0);
    rd(A_MSKD, d); check("R9 masked reg off", d, 0);
    wr(A_MASK, 1);
    check("R9 irq on", {31'b0, irqOut}, 1);
    rd(A_MSKD, d); check("R9 masked reg on", d, 1);

    // R4 locked write
    wr(valAddr(0), 5);
    rd(valAddr(0), d); check("R4 locked", d, 255);
    wr(cfgAddr(0), 0);
    wr(valAddr(0), 7);
    rd(valAddr(0), d); check("R4 unlocked", d, 7);
    rd(A_RAW, d); check("R7 sticky after rewrite", d, 1);

    // R8 clear
    wr(A_CLR, 0);
    rd(A_RAW, d); check("R8 zero write", d, 1);
    wr(A_CLR, 1);
    rd(A_RAW, d); check("R8 clear", d, 0);
    check("R8 irq low", {31'b0, irqOut}, 0);

    // R7 write of all-ones does not set
    wr(cfgAddr(0), 32'h100);
    wr(valAddr(0), 255);
    rd(A_RAW, d); check("R7 write no set", d, 0);

    // R7 saturation without irq enable
    wr(cfgAddr(1), 0);
    wr(valAddr(1), 253);
    wr(cfgAddr(1), 4);
    pulse(NEV'(8), 5);
    rd(valAddr(1), d); check("R3 ctr1 saturate", d, 255);
    rd(A_RAW, d); check("R7 no irq enable", d, 0);

    // R8 set wins over clear in same cycle
    wr(cfgAddr(0), 0);
    wr(valAddr(0), 254);
    wr(cfgAddr(0), 32'h102);
    evtPulse = NEV'(2);
    regWrEn = 1'b1; regAddr = A_CLR; regWrData = 1;
    @(posedge clk); #1;
    regWrEn = 1'b0; evtPulse = '0;
    rd(A_RAW, d); check("R8 set wins", d, 1);
    rd(valAddr(0), d); check("R3 reached max", d, 255);

    summary();
    $finish;
  end

endmodule